// File: doc/BRIEF.md
# Local Interrupt Timer with Clock Divider

This block is a down-counting timer that raises an interrupt request when its count runs out. Software programs it through a single write port that selects one of four registers: the start value of the count, the clock divide setting, the timer's vector-table entry (vector, mask, repeat mode) and a control word that carries the software enable. The count advances once per divided tick, where the divider is a power of two chosen by a 3-bit code taken from non-adjacent bits of the divide setting.

A write of the start value restarts the count from that value and clears the divider phase. When the count reaches zero the timer either stops there (one-shot) or loads the start value again (repeat). Each expiry produces a one-cycle request carrying the entry's vector, but only when both the hardware enable pin and the software enable are set and the entry is not masked. Turning the software enable off masks the entry, and while it is off any write to the entry is stored masked.

The counter is a three-state machine. IDLE holds a count of zero after reset or after a start value of zero. RUN counts down. DONE holds zero after a one-shot expiry. The transitions are START (IDLE or DONE to RUN, on a nonzero start write), RESTART (RUN to RUN, on any nonzero start write), STOP (any state to IDLE, on a zero start write), RELOAD (RUN to RUN, at a repeat-mode expiry) and FINISH (RUN to DONE, at a one-shot expiry).

Top module: `tick_timer`

## Requirements
- R1: The write select picks the register: 0 start count, 1 divide setting, 2 timer entry, 3 control. The divide code is {setting bit 3, setting bits 1:0}, and the divisor is 2 to the power ((code+1) mod 8). Code 7 divides by 1, and setting bit 2 has no effect.
- R2: A start-count write cancels any count in progress, loads the new value and restarts the divider phase.
- R3: The current count equals the start value minus the divided ticks seen since the start write. The first decrement comes one divisor period after the write edge.
- R4: In one-shot mode (entry bit 17 clear) the count stops at 0 and stays there until the next start write.
- R5: In repeat mode (entry bit 17 set) the count is reloaded with the start value on the edge where it would reach 0, so expiries recur every start×divisor cycles.
- R6: An expiry raises a request carrying the entry vector (bits 7:0) only when the hardware enable is high, the software enable is set and the entry mask (bit 16) is clear. Otherwise the expiry is silent.
- R7: The entry reads back vector at bits 7:0, mask at 16 and mode at 17, with all other bits 0. A write to the entry while the software enable is off stores the mask set.
- R8: A control write with bit 8 clear turns the software enable off and sets the entry mask. Bit 8 set turns it on.
- R9: After reset the entry is masked with vector 0 in one-shot mode, the start count and divide setting are 0, the software enable is off and the current count is 0.
- R10: A start value of 0 leaves the timer stopped with a count of 0, and no request follows.
- R11: The request is high for exactly one cycle: the cycle after the edge on which the count reaches 0, which is start×divisor cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_hw_en | input | 1 | Hardware enable for interrupt delivery |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 start, 1 divide, 2 entry, 3 control) |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| lvt_value | output | 32 | Timer entry readback |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector carried with the request |

## Verification
All eight divide codes are run through one-shot expiries, together with a setting whose only set bit is bit 2. Because each row expects a different expiry cycle, a wrong bit packing, a missing increment or a divider that is off by one shows up as a mismatch. Repeat mode is tested with the interval between requests, which separates a proper reload from a stop or from a reload that costs an extra cycle. Masked, hardware-disabled and zero-start runs show that the gates block the request while the count still runs down. A start write in mid-count, and a read taken part way through a divisor period, show whether the restart clears the divider phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    localparam logic [1:0] SEL_INIT = 2'd0;
    localparam logic [1:0] SEL_DIV  = 2'd1;
    localparam logic [1:0] SEL_LVT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int VEC_W        = 8;
    localparam int LVT_MASK_BIT = 16;
    localparam int LVT_PER_BIT  = 17;
    localparam int CTRL_EN_BIT  = 8;
    localparam int SHIFT_W      = 3;

    // Packed code {b3,b1,b0}; exponent is code+1 wrapping in 3 bits.
    function automatic logic [SHIFT_W-1:0] div_exp(input logic [SHIFT_W-1:0] code);
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W-1:0]   init_wr,
    input  logic [SHIFT_W-1:0] div_code_wr,
    input  logic [VEC_W-1:0]   vec_wr,
    input  logic               mask_wr,
    input  logic               per_wr,
    input  logic               en_wr,
    output logic [CNT_W-1:0]   init_q,
    output logic [SHIFT_W-1:0] shift_o,
    output logic [VEC_W-1:0]   vec_q,
    output logic               mask_q,
    output logic               per_q,
    output logic               sw_en_q,
    output logic [31:0]        lvt_word
);

    logic [SHIFT_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q  <= '0;
            code_q  <= '0;
            vec_q   <= '0;
            mask_q  <= 1'b1;
            per_q   <= 1'b0;
            sw_en_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_INIT: init_q <= init_wr;
                SEL_DIV:  code_q <= div_code_wr;
                SEL_LVT: begin
                    vec_q  <= vec_wr;
                    per_q  <= per_wr;
                    mask_q <= mask_wr | ~sw_en_q;
                end
                SEL_CTRL: begin
                    sw_en_q <= en_wr;
                    if (!en_wr) mask_q <= 1'b1;
                end
            endcase
        end
    end

    assign shift_o = div_exp(code_q);

    always_comb begin
        lvt_word               = '0;
        lvt_word[VEC_W-1:0]    = vec_q;
        lvt_word[LVT_MASK_BIT] = mask_q;
        lvt_word[LVT_PER_BIT]  = per_q;
    end

    // R7 / R8: a disabled unit never holds an unmasked entry
    p_masked_while_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en_q |-> mask_q);

    // R8: a control write clearing the enable leaves the entry masked
    p_disable_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && !en_wr) |=> (mask_q && !sw_en_q));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int PRE_W = (2 ** SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   limit;

    assign limit = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
    assign tick  = run && !clr && ({1'b0, pre_q} >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R2: a restart always begins a fresh divider period
    p_phase_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    input  logic             deliver_en_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o
);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    // next-state: START / RESTART / STOP on load, RELOAD / FINISH at expiry
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
            st_d  = (load_val_i != '0) ? ST_RUN : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: ;
                ST_RUN: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_W'(1)) begin
                            expire = 1'b1;
                            if (periodic_i) begin
                                cnt_d = init_i;
                            end else begin
                                cnt_d = '0;
                                st_d  = ST_DONE;
                            end
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            irq_vec_o <= '0;
        end else begin
            irq_o     <= expire && deliver_en_i;
            if (expire) irq_vec_o <= vec_i;
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = (st_q == ST_RUN);

    // R6: a request implies delivery was allowed at the expiry edge
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(deliver_en_i));

    // R4: a finished one-shot holds zero until a new start write
    p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !load_i) |=> (st_q == ST_DONE && cnt_q == '0));

    // R3: while running the count moves by at most one or reloads
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !load_i) |=>
            (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))
             || cnt_q == $past(init_i)));

    // R10: a zero start value parks the counter
    p_zero_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (st_q == ST_IDLE && cnt_q == '0 && !irq_o));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_hw_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic [31:0]       lvt_value,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);

    logic [CNT_W-1:0]   init_q;
    logic [SHIFT_W-1:0] shift;
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q, per_q, sw_en_q;
    logic               load, tick, running, deliver_en;

    assign load       = wr_en && (wr_sel == SEL_INIT);
    assign deliver_en = unit_hw_en && sw_en_q && !mask_q;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .init_wr     (wr_data[CNT_W-1:0]),
        .div_code_wr ({wr_data[3], wr_data[1:0]}),
        .vec_wr      (wr_data[VEC_W-1:0]),
        .mask_wr     (wr_data[LVT_MASK_BIT]),
        .per_wr      (wr_data[LVT_PER_BIT]),
        .en_wr       (wr_data[CTRL_EN_BIT]),
        .init_q      (init_q),
        .shift_o     (shift),
        .vec_q       (vec_q),
        .mask_q      (mask_q),
        .per_q       (per_q),
        .sw_en_q     (sw_en_q),
        .lvt_word    (lvt_value)
    );

    tmr_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .run   (running),
        .shift (shift),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .load_val_i   (wr_data[CNT_W-1:0]),
        .init_i       (init_q),
        .tick_i       (tick),
        .periodic_i   (per_q),
        .deliver_en_i (deliver_en),
        .vec_i        (vec_q),
        .cnt_o        (cur_count),
        .run_o        (running),
        .irq_o        (irq_req),
        .irq_vec_o    (irq_vec)
    );

    // R11: one-shot expiry never yields back-to-back requests
    p_pulse_oneshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !per_q && !wr_en) |=> !irq_req);

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_hw_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic [31:0] lvt_value;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .unit_hw_en(unit_hw_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cur_count(cur_count), .lvt_value(lvt_value),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // {divide setting, start count, expected cycles to request}
    localparam logic [35:0] TBL [0:9] = '{
        {4'h0, 16'd3, 16'd6},
        {4'h1, 16'd4, 16'd16},
        {4'h2, 16'd3, 16'd24},
        {4'h3, 16'd2, 16'd32},
        {4'h8, 16'd2, 16'd64},
        {4'h9, 16'd1, 16'd64},
        {4'hA, 16'd1, 16'd128},
        {4'hB, 16'd5, 16'd5},
        {4'h4, 16'd3, 16'd6},
        {4'hF, 16'd4, 16'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        while (!irq_req && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic count_pulses(input int n, output int p);
        p = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq_req) p++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 count", cur_count, 32'd0);
        chk("R9 entry", lvt_value, 32'h0001_0000);
        chk("R9 irq", {31'd0, irq_req}, 32'd0);

        // R7 forced mask while disabled
        wr(2'd2, 32'h0000_0020);
        chk("R7 forced mask", lvt_value, 32'h0001_0020);
        wr(2'd3, 32'h0000_0100);
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R7 field layout", lvt_value, 32'h0003_00FF);
        wr(2'd2, 32'h0000_0041);
        chk("R7 unmasked write", lvt_value, 32'h0000_0041);
        // R8 clearing enable masks
        wr(2'd3, 32'h0000_0000);
        chk("R8 disable masks", lvt_value, 32'h0001_0041);
        wr(2'd3, 32'h0000_0100);

        // table: R1 divisor decoding, R3 timing, R11 single pulse, R4 hold
        wr(2'd2, 32'h0000_0055);
        for (int i = 0; i < 10; i++) begin
            wr(2'd1, {28'd0, TBL[i][35:32]});
            wr(2'd0, {16'd0, TBL[i][31:16]});
            wait_irq(cyc);
            chk($sformatf("R1 row %0d expiry cycle", i), cyc, {16'd0, TBL[i][15:0]});
            chk("R6 vector", {24'd0, irq_vec}, 32'h55);
            @(negedge clk);
            chk("R11 pulse width", {31'd0, irq_req}, 32'd0);
            count_pulses(4, p);
            chk("R4 no repeat", p, 0);
            chk("R4 held at zero", cur_count, 32'd0);
        end

        // R3 mid-period read with divide by 4
        wr(2'd1, 32'h1);
        wr(2'd0, 32'd3);
        repeat (5) @(negedge clk);
        chk("R3 mid count", cur_count, 32'd2);
        wait_irq(cyc);
        chk("R3 remaining", cyc, 7);

        // R2 restart mid count, divide by 1
        wr(2'd1, 32'hB);
        wr(2'd0, 32'd10);
        repeat (4) @(negedge clk);
        chk("R3 count after 4", cur_count, 32'd6);
        wr(2'd0, 32'd5);
        chk("R2 reloaded", cur_count, 32'd5);
        wait_irq(cyc);
        chk("R2 expiry after restart", cyc, 5);

        // R5 repeat mode
        wr(2'd2, 32'h0002_0040);
        wr(2'd0, 32'd3);
        wait_irq(cyc);
        chk("R5 first expiry", cyc, 3);
        chk("R5 reloaded count", cur_count, 32'd3);
        chk("R5 vector", {24'd0, irq_vec}, 32'h40);
        count_pulses(9, p);
        chk("R5 periodic pulses", p, 3);
        wr(2'd2, 32'h0000_0041);

        // R6 masked entry
        wr(2'd2, 32'h0001_0041);
        wr(2'd0, 32'd4);
        count_pulses(10, p);
        chk("R6 masked silent", p, 0);
        chk("R6 masked count ran", cur_count, 32'd0);

        // R6 hardware enable low
        wr(2'd2, 32'h0000_0041);
        unit_hw_en = 1'b0;
        wr(2'd0, 32'd4);
        count_pulses(10, p);
        chk("R6 hw disabled silent", p, 0);
        chk("R6 hw disabled count", cur_count, 32'd0);
        unit_hw_en = 1'b1;

        // R10 zero start
        wr(2'd0, 32'd0);
        count_pulses(20, p);
        chk("R10 no request", p, 0);
        chk("R10 count zero", cur_count, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule